// File: doc/BRIEF.md
# Level-Priority Vectored Interrupt Controller

This block gathers a parameterised set of interrupt sources for a small processor core and presents one request at a time. Software programs it through a byte-wide register port: one global configuration byte, one threshold byte, a read-only information word, and four bytes per source covering the pending flag, the enable flag, the trigger and vectoring attributes, and a control byte. Each source is sampled as level, rising-edge or falling-edge triggered, as its attributes select.

The control byte of every source is split at run time into a level part and a priority part. A global field sets how many upper bits form the level. Among the sources that are both pending and enabled, the controller picks a winner by level, then by priority, then by source number. It raises the request only when the winning level is strictly above the threshold byte. The winner's number, its 8-bit level and its vectored flag are presented with the request. A claim acknowledge from the core clears the pending flag of an edge-triggered winner.

Top module: `lvl_prio_irq_ctrl`

## Requirements
- R1: After reset all configuration, threshold and per-source state is zero and `irq_req` is low. The control byte of every source then reads 0x0F.
- R2: Register map. Global configuration is at 0x000, with the level-width field in bits [4:1] and the other bits reading 0. The information word occupies 0x004..0x007, least significant byte first. It holds the source count in bits [15:0] and the implemented control width in bits [19:16]. The threshold byte is at 0x00B. Source i uses the bytes at 0x1000+4*i: +0 pending, +1 enable, +2 attributes, +3 control. Read data appears in the cycle after `reg_rd_en`.
- R3: An access to any other offset, including a source number at or above the source count, is ignored on write and reads back 0.
- R4: Only the upper 4 bits of a control byte are stored. Its lower 4 bits always read as ones.
- R5: Let n be the level-width field. The level of a source is its control byte with the top n bits kept and all lower bits forced to one; n = 0 gives level 0xFF. The priority is formed from the stored bits below the level bits.
- R6: The winner is the pending and enabled source with the highest level. Ties go to the higher priority, then to the higher source number. `irq_id` and `irq_level` show the winner.
- R7: `irq_req` is high only when a winner exists and its level is strictly greater than the threshold byte.
- R8: With attribute bit 1 clear (level trigger), the pending flag equals the input one cycle earlier, and software writes to it have no effect.
- R9: With attribute bit 1 set (edge trigger), the chosen edge of the input sets the pending flag on the next clock edge. Attribute bit 2 selects the edge: 0 rising, 1 falling. The flag stays set after the input returns.
- R10: For an edge source, writing bit 0 of the pending byte sets or clears the flag. Bit 0 of the enable byte gates the source out of arbitration without clearing its pending flag.
- R11: A `claim_ack` pulse while `irq_req` is high clears the pending flag of an edge-triggered winner. A new edge in the same cycle takes precedence over the claim. The claim leaves a level-triggered winner unchanged.
- R12: `irq_vec` equals attribute bit 0 of the winning source.
- R13: Level-width values above 4 behave as 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | NUM_SRC | Raw interrupt inputs, one per source |
| reg_wr_en | input | 1 | Byte write strobe |
| reg_rd_en | input | 1 | Byte read strobe |
| reg_addr | input | 13 | Byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| claim_ack | input | 1 | Core acknowledges the presented request |
| irq_req | output | 1 | Interrupt request |
| irq_id | output | ID_W | Winning source number |
| irq_level | output | 8 | Winning level |
| irq_vec | output | 1 | Winner requests vectored handling |

## Verification
A corrupted pending flag shows at `irq_req` and `irq_id` on the first clock edge after it goes wrong. A stale edge history shows within one cycle as a missed edge or a spurious one. A wrong level/priority split shows at once as a different winner or a different `irq_level`. Register decode faults show in the read byte one cycle after the address, or as a winner change after a write that should have been ignored.

// File: rtl/lpic_pkg.sv
package lpic_pkg;

  // Clamp the level-width field to the number of implemented control bits.
  function automatic logic [3:0] clamp_nl(input logic [3:0] nl, input int unsigned impl);
    logic [3:0] lim;
    lim = 4'(impl);
    return (nl > lim) ? lim : nl;
  endfunction

  // Level: keep the top nl bits of the control byte, force the rest to one.
  function automatic logic [7:0] level_of(input logic [7:0] ctl_byte, input logic [3:0] nl);
    logic [7:0] keep;
    keep = ~(8'hFF >> nl);
    return (ctl_byte & keep) | ~keep;
  endfunction

  // Priority: the bits below the level bits.
  function automatic logic [7:0] prio_of(input logic [7:0] ctl_byte, input logic [3:0] nl);
    return ctl_byte & (8'hFF >> nl);
  endfunction

endpackage

// File: rtl/lpic_src_slot.sv
module lpic_src_slot #(
  parameter int CTL_IMPL = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                src_i,
  input  logic                wr_pend_i,
  input  logic                wr_ie_i,
  input  logic                wr_attr_i,
  input  logic                wr_ctl_i,
  input  logic [2:0]          attr_d_i,
  input  logic [CTL_IMPL-1:0] ctl_d_i,
  input  logic                claim_i,
  output logic                pend_o,
  output logic                ie_o,
  output logic [2:0]          attr_o,
  output logic [CTL_IMPL-1:0] ctl_o,
  output logic                edge_evt_o
);

  logic src_prev_q;
  logic is_edge_mode;
  logic want_fall;

  assign is_edge_mode = attr_o[1];
  assign want_fall    = attr_o[2];

  // Selected edge seen between the previous and current sample.
  assign edge_evt_o = is_edge_mode &
                      (want_fall ? (src_prev_q & ~src_i) : (src_i & ~src_prev_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_prev_q <= 1'b0;
    end else begin
      src_prev_q <= src_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o <= 1'b0;
    end else if (!is_edge_mode) begin
      pend_o <= src_i;
    end else if (edge_evt_o) begin
      pend_o <= 1'b1;
    end else if (wr_pend_i) begin
      pend_o <= attr_d_i[0];
    end else if (claim_i) begin
      pend_o <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_o   <= 1'b0;
      attr_o <= 3'b000;
      ctl_o  <= '0;
    end else begin
      if (wr_ie_i)   ie_o   <= attr_d_i[0];
      if (wr_attr_i) attr_o <= attr_d_i;
      if (wr_ctl_i)  ctl_o  <= ctl_d_i;
    end
  end

endmodule

// File: rtl/lpic_arb.sv
module lpic_arb #(
  parameter int NUM_SRC = 8,
  parameter int ID_W    = 3
) (
  input  logic [NUM_SRC-1:0]      cand_i,
  input  logic [NUM_SRC-1:0][7:0] lvl_i,
  input  logic [NUM_SRC-1:0][7:0] prio_i,
  output logic                    any_o,
  output logic [ID_W-1:0]         win_id_o,
  output logic [7:0]              win_lvl_o
);

  logic [15:0] best_key;

  // Ascending scan with >= so that a later (higher) source wins a full tie.
  always_comb begin
    any_o    = 1'b0;
    win_id_o = '0;
    best_key = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand_i[i] && (!any_o || {lvl_i[i], prio_i[i]} >= best_key)) begin
        any_o    = 1'b1;
        best_key = {lvl_i[i], prio_i[i]};
        win_id_o = ID_W'(i);
      end
    end
  end

  assign win_lvl_o = any_o ? best_key[15:8] : 8'h00;

endmodule

// File: rtl/lvl_prio_irq_ctrl.sv
module lvl_prio_irq_ctrl
  import lpic_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int CTL_IMPL = 4,
  localparam int ID_W    = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               reg_wr_en,
  input  logic               reg_rd_en,
  input  logic [12:0]        reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic               claim_ack,
  output logic               irq_req,
  output logic [ID_W-1:0]    irq_id,
  output logic [7:0]         irq_level,
  output logic               irq_vec
);

  localparam int          CTL_FILL  = 8 - CTL_IMPL;
  localparam logic [9:0]  NSRC_W    = 10'(NUM_SRC);
  localparam logic [31:0] INFO_WORD = {12'h000, 4'(CTL_IMPL), 16'(NUM_SRC)};

  // Global state
  logic [3:0] cfg_nl_q;
  logic [7:0] thr_q;
  logic [3:0] nl_eff;

  // Per-source state
  logic [NUM_SRC-1:0]               pend_q;
  logic [NUM_SRC-1:0]               ie_q;
  logic [NUM_SRC-1:0][2:0]          attr_q;
  logic [NUM_SRC-1:0][CTL_IMPL-1:0] ctl_q;
  logic [NUM_SRC-1:0]               edge_evt;
  logic [NUM_SRC-1:0]               attr_edge;
  logic [NUM_SRC-1:0][7:0]          src_lvl;
  logic [NUM_SRC-1:0][7:0]          src_prio;
  logic [NUM_SRC-1:0]               cand;
  logic [NUM_SRC-1:0]               claim_vec;

  // Decode
  logic       glb_space;
  logic [9:0] src_idx;
  logic       src_hit;
  logic [1:0] fld;
  logic       rd_reserved;
  logic [7:0] rd_mux;

  // Arbitration
  logic            win_any;
  logic [ID_W-1:0] win_id;
  logic [7:0]      win_lvl;

  assign glb_space = ~reg_addr[12];
  assign src_idx   = reg_addr[11:2];
  assign src_hit   = reg_addr[12] && (src_idx < NSRC_W);
  assign fld       = reg_addr[1:0];
  assign nl_eff    = clamp_nl(cfg_nl_q, CTL_IMPL);

  // Global registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_nl_q <= 4'h0;
      thr_q    <= 8'h00;
    end else if (reg_wr_en && glb_space) begin
      if (reg_addr[11:0] == 12'h000) cfg_nl_q <= reg_wdata[4:1];
      if (reg_addr[11:0] == 12'h00B) thr_q    <= reg_wdata;
    end
  end

  // Source slots
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic sel;
    logic [7:0] ctl_byte;
    assign sel = reg_wr_en && src_hit && (src_idx == 10'(g));

    lpic_src_slot #(.CTL_IMPL(CTL_IMPL)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_i      (src_in[g]),
      .wr_pend_i  (sel && fld == 2'd0),
      .wr_ie_i    (sel && fld == 2'd1),
      .wr_attr_i  (sel && fld == 2'd2),
      .wr_ctl_i   (sel && fld == 2'd3),
      .attr_d_i   (reg_wdata[2:0]),
      .ctl_d_i    (reg_wdata[7:CTL_FILL]),
      .claim_i    (claim_vec[g]),
      .pend_o     (pend_q[g]),
      .ie_o       (ie_q[g]),
      .attr_o     (attr_q[g]),
      .ctl_o      (ctl_q[g]),
      .edge_evt_o (edge_evt[g])
    );

    assign ctl_byte     = {ctl_q[g], {CTL_FILL{1'b1}}};
    assign src_lvl[g]   = level_of(ctl_byte, nl_eff);
    assign src_prio[g]  = prio_of(ctl_byte, nl_eff);
    assign cand[g]      = pend_q[g] & ie_q[g];
    assign attr_edge[g] = attr_q[g][1];
    assign claim_vec[g] = claim_ack && irq_req && (win_id == ID_W'(g));
  end

  lpic_arb #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_arb (
    .cand_i    (cand),
    .lvl_i     (src_lvl),
    .prio_i    (src_prio),
    .any_o     (win_any),
    .win_id_o  (win_id),
    .win_lvl_o (win_lvl)
  );

  assign irq_req   = win_any && (win_lvl > thr_q);
  assign irq_id    = win_id;
  assign irq_level = win_lvl;
  assign irq_vec   = attr_q[win_id][0];

  // Read multiplexer
  always_comb begin
    rd_mux      = 8'h00;
    rd_reserved = 1'b1;
    if (glb_space) begin
      case (reg_addr[11:0])
        12'h000: begin rd_mux = {3'b000, cfg_nl_q, 1'b0}; rd_reserved = 1'b0; end
        12'h004, 12'h005, 12'h006, 12'h007: begin
          rd_mux      = INFO_WORD[8*fld +: 8];
          rd_reserved = 1'b0;
        end
        12'h00B: begin rd_mux = thr_q; rd_reserved = 1'b0; end
        default: ;
      endcase
    end else if (src_hit) begin
      rd_reserved = 1'b0;
      for (int i = 0; i < NUM_SRC; i++) begin
        if (src_idx == 10'(i)) begin
          case (fld)
            2'd0:    rd_mux = {7'b0, pend_q[i]};
            2'd1:    rd_mux = {7'b0, ie_q[i]};
            2'd2:    rd_mux = {5'b0, attr_q[i]};
            default: rd_mux = {ctl_q[i], {CTL_FILL{1'b1}}};
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= 8'h00;
    end else if (reg_rd_en) begin
      reg_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/lpic_chk.sv
module lpic_chk #(
  parameter int NUM_SRC = 8,
  parameter int ID_W    = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_in,
  input logic               reg_rd_en,
  input logic               rd_reserved,
  input logic [7:0]         reg_rdata,
  input logic               irq_req,
  input logic [ID_W-1:0]    irq_id,
  input logic [7:0]         irq_level,
  input logic [7:0]         thr_q,
  input logic [NUM_SRC-1:0] pend_q,
  input logic [NUM_SRC-1:0] ie_q,
  input logic [NUM_SRC-1:0] attr_edge,
  input logic [NUM_SRC-1:0] edge_evt
);

  AST_REQ_ABOVE_THR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_level > thr_q)); // R7

  AST_WINNER_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (pend_q[irq_id] && ie_q[irq_id])); // R6

  AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_rd_en) && $past(rd_reserved)) |-> (reg_rdata == 8'h00)); // R3

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
    AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(attr_edge[g])) |-> (pend_q[g] == $past(src_in[g]))); // R8

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      edge_evt[g] |=> pend_q[g]); // R9
  end

endmodule

bind lvl_prio_irq_ctrl lpic_chk #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .src_in      (src_in),
  .reg_rd_en   (reg_rd_en),
  .rd_reserved (rd_reserved),
  .reg_rdata   (reg_rdata),
  .irq_req     (irq_req),
  .irq_id      (irq_id),
  .irq_level   (irq_level),
  .thr_q       (thr_q),
  .pend_q      (pend_q),
  .ie_q        (ie_q),
  .attr_edge   (attr_edge),
  .edge_evt    (edge_evt)
);

// File: tb/tb_lvl_prio_irq_ctrl.sv
module tb_lvl_prio_irq_ctrl;

  localparam int NUM_SRC = 8;
  localparam int ID_W    = 3;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NUM_SRC-1:0] src_in = '0;
  logic               reg_wr_en = 1'b0;
  logic               reg_rd_en = 1'b0;
  logic [12:0]        reg_addr = '0;
  logic [7:0]         reg_wdata = '0;
  logic [7:0]         reg_rdata;
  logic               claim_ack = 1'b0;
  logic               irq_req;
  logic [ID_W-1:0]    irq_id;
  logic [7:0]         irq_level;
  logic               irq_vec;

  int n_run  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  lvl_prio_irq_ctrl #(.NUM_SRC(NUM_SRC), .CTL_IMPL(4)) dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .claim_ack(claim_ack),
    .irq_req(irq_req), .irq_id(irq_id), .irq_level(irq_level), .irq_vec(irq_vec)
  );

  typedef struct packed {
    logic [3:0] nl;
    logic [7:0] thr;
    logic [7:0] c2;
    logic [7:0] c5;
    logic       req;
    logic [2:0] id;
    logic [7:0] lvl;
  } vec_t;

  // Sources 2 and 5 level-triggered, inputs high, enabled.
  localparam vec_t VEC [0:8] = '{
    '{4'd0, 8'h00, 8'h00, 8'h00, 1'b1, 3'd5, 8'hFF},  // full tie -> higher id
    '{4'd4, 8'h00, 8'h80, 8'h40, 1'b1, 3'd2, 8'h8F},  // level decides
    '{4'd2, 8'h00, 8'h40, 8'h70, 1'b1, 3'd5, 8'h7F},  // same level, priority decides
    '{4'd2, 8'h00, 8'h70, 8'h40, 1'b1, 3'd2, 8'h7F},  // priority beats id
    '{4'd9, 8'h00, 8'h30, 8'h20, 1'b1, 3'd2, 8'h3F},  // width above 4 acts as 4
    '{4'd1, 8'h00, 8'h80, 8'h00, 1'b1, 3'd2, 8'hFF},  // one level bit
    '{4'd4, 8'h4F, 8'h40, 8'h40, 1'b0, 3'd5, 8'h4F},  // level equal threshold
    '{4'd4, 8'h4E, 8'h40, 8'h40, 1'b1, 3'd5, 8'h4F},  // level just above
    '{4'd3, 8'h00, 8'hA0, 8'hB0, 1'b1, 3'd5, 8'hBF}   // nl=3 priority bit
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic claim();
    @(negedge clk);
    claim_ack = 1'b1;
    @(negedge clk);
    claim_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state and map
    chk("R1 irq_req after reset", irq_req, 1'b0);
    rd(13'h000, d); chk("R1 cfg after reset", d, 8'h00);
    rd(13'h1003, d); chk("R1 ctl after reset", d, 8'h0F);
    rd(13'h004, d); chk("R2 info byte0", d, 8'h08);
    rd(13'h006, d); chk("R2 info byte2", d, 8'h04);

    // Table of arbitration vectors
    wr(13'h1009, 8'h01);
    wr(13'h1015, 8'h01);
    @(negedge clk);
    src_in[2] = 1'b1; src_in[5] = 1'b1;
    foreach (VEC[k]) begin
      wr(13'h000, {3'b000, VEC[k].nl, 1'b0});
      wr(13'h00B, VEC[k].thr);
      wr(13'h100B, VEC[k].c2);
      wr(13'h1017, VEC[k].c5);
      @(negedge clk);
      chk($sformatf("R7 vec%0d req", k), irq_req, VEC[k].req);
      if (VEC[k].req) begin
        chk($sformatf("R6 vec%0d id", k), irq_id, VEC[k].id);
        chk($sformatf("R5 R13 vec%0d level", k), irq_level, VEC[k].lvl);
      end
    end

    // Configuration readback
    rd(13'h000, d); chk("R2 cfg readback", d, 8'h06);
    wr(13'h000, 8'hFF);
    rd(13'h000, d); chk("R2 cfg other bits zero", d, 8'h1E);
    wr(13'h000, 8'h08);
    rd(13'h00B, d); chk("R2 threshold readback", d, 8'h00);

    // Control byte low bits
    wr(13'h1007, 8'h5A);
    rd(13'h1007, d); chk("R4 ctl low ones", d, 8'h5F);

    // Reserved offsets
    wr(13'h001, 8'hFF);
    rd(13'h001, d); chk("R3 reserved global", d, 8'h00);
    wr(13'h1021, 8'h00);
    rd(13'h1020, d); chk("R3 reserved source", d, 8'h00);
    chk("R3 write had no effect", irq_req, 1'b1);

    // Level-trigger pending ignores software
    wr(13'h100C, 8'h01);
    rd(13'h100C, d); chk("R8 sw write ignored", d, 8'h00);
    @(negedge clk); src_in[3] = 1'b1;
    rd(13'h100C, d); chk("R8 follows input", d, 8'h01);
    src_in = '0;
    @(negedge clk); @(negedge clk);
    chk("R8 pending drops with input", irq_req, 1'b0);

    // Rising edge on source 0
    wr(13'h1002, 8'h02);
    wr(13'h1001, 8'h01);
    wr(13'h1003, 8'hF0);
    @(negedge clk); src_in[0] = 1'b1;
    @(negedge clk); src_in[0] = 1'b0;
    chk("R9 rising edge req", irq_req, 1'b1);
    chk("R9 rising edge id", irq_id, 3'd0);
    chk("R6 edge level", irq_level, 8'hFF);
    chk("R12 non-vectored", irq_vec, 1'b0);
    @(negedge clk);
    chk("R9 pending held", irq_req, 1'b1);
    claim();
    chk("R11 claim clears edge", irq_req, 1'b0);

    // Falling edge, vectored
    wr(13'h1002, 8'h07);
    @(negedge clk); src_in[0] = 1'b1;
    @(negedge clk);
    chk("R9 rise ignored in falling mode", irq_req, 1'b0);
    src_in[0] = 1'b0;
    @(negedge clk);
    chk("R9 falling edge req", irq_req, 1'b1);
    chk("R12 vectored flag", irq_vec, 1'b1);
    claim();

    // Software pending and enable
    wr(13'h1000, 8'h01);
    chk("R10 sw set pending", irq_req, 1'b1);
    wr(13'h1000, 8'h00);
    chk("R10 sw clear pending", irq_req, 1'b0);
    wr(13'h1000, 8'h01);
    wr(13'h1001, 8'h00);
    chk("R10 disable gates", irq_req, 1'b0);
    rd(13'h1000, d); chk("R10 pending kept when disabled", d, 8'h01);
    wr(13'h1000, 8'h00);

    // Claim on a level source
    wr(13'h100D, 8'h01);
    @(negedge clk); src_in[3] = 1'b1;
    @(negedge clk);
    chk("R11 level source id", irq_id, 3'd3);
    claim();
    chk("R11 claim leaves level source", irq_req, 1'b1);
    chk("R11 level source level", irq_level, 8'h0F);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule